// File: doc/BRIEF.md
# Chain-Mode DMA Tag Sequencer

A single-channel DMA engine that walks a linked chain of 64-bit descriptors ("tags") held in memory. Each tag carries an opcode, a quadword count and an address. The opcode decides where the data lies: directly behind the tag, or at the address the tag holds. It also decides where the next tag lies: directly behind the data, at the tag's address, or on a two-entry return stack kept for call and return tags. Data quadwords are read over a 128-bit request/acknowledge read port and passed out on a data stream.

Software loads a control word and a first tag address with a single write while the channel is idle. The start bit, together with chain mode, launches the walk. The channel then reads its own tags until one of four things happens: an end-type tag, a tag interrupt, a stack fault or an unmapped address. Each cause leaves its own sticky flag. The control word reads back the running state, the stack depth and the upper half of the most recent tag.

The sequencer is a five-state machine. Its states are IDLE, FETCH, DECODE, MOVE and WRAP, with these transitions:
- IDLE→FETCH on a start write.
- FETCH→DECODE on tag acknowledge.
- FETCH→IDLE on an unmapped tag address.
- DECODE→MOVE for a non-zero count, DECODE→WRAP for a zero count, DECODE→IDLE on a stack fault.
- MOVE→WRAP on the last beat, MOVE→IDLE on an unmapped data address.
- WRAP→FETCH to continue, WRAP→IDLE on end or tag interrupt.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset, `ctrl_out` is 0, all four flags are 0 and `mem_req` is low.
- R2: A write while idle starts the chain only when `cfg_ctrl` bit 8 (start) is 1 and bits 3:2 (mode) equal 1. With any other mode the start bit reads back 0 and no request is made. Writes while running are ignored.
- R3: The tag's low word has the count in bits 15:0, the opcode in bits 30:28 and the interrupt bit in bit 31. The high word holds the address, with bit 31 as the scratchpad select. On every tag read, tag bits 31:16 appear in `ctrl_out` bits 31:16.
- R4: Opcodes 1 (continue), 2 (jump), 5 (call), 6 (return) and 7 (end) read their data from tag address+16. Opcodes 1 and 7 place the next tag just past the data; opcode 2 places it at the tag's address.
- R5: Opcodes 0, 3 and 4 read data from the tag's address. Opcodes 3 and 4 then continue with the tag at tag address+16. Opcodes 0 and 7 end the chain after their data, set `done_flag` and clear the start bit.
- R6: A call pushes the address just past its data and jumps to the tag's address. A return pops the next tag address. `ctrl_out` bits 5:4 show the stack depth.
- R7: A call with a full stack (depth 2), or a return with an empty one, sets `stackerr_flag`, clears the start bit and moves no data for that tag.
- R8: With `ctrl_out` bit 7 (tag-interrupt enable) set, a tag with its interrupt bit stops the chain after that tag's data and sets `tagirq_flag`. With bit 7 clear, the interrupt bit has no effect.
- R9: Every address is masked with 0x1FFFFFF0. With the select bit set, the port address is the raw address and 0x3FF0, with `mem_spr` high. Masked addresses 0x10000000–0x10003FFF also map to scratchpad; addresses below `MAIN_BYTES` go to main memory.
- R10: An address in no region sets `buserr_flag` and clears the start bit, and no request is made for it.
- R11: A tag whose count is 0 moves no data.
- R12: `mem_req` stays high with a stable, 16-byte-aligned address until `mem_ack`. Each acknowledged data request yields exactly one `dout_valid` beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe (accepted only when idle) |
| cfg_ctrl | input | 32 | Control word to write |
| cfg_tadr | input | 32 | First tag address to write |
| ctrl_out | output | 32 | Control word readback: tag bits, start, enables, stack depth, mode, direction |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Mapped byte address of the request |
| mem_spr | output | 1 | Request targets scratchpad |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 128 | Read data |
| dout_valid | output | 1 | Data quadword valid |
| dout_data | output | 128 | Data quadword |
| done_flag | output | 1 | Chain ended normally |
| tagirq_flag | output | 1 | Chain stopped on a tag interrupt |
| buserr_flag | output | 1 | Unmapped address seen |
| stackerr_flag | output | 1 | Stack overflow or underflow |

## Verification
An end-type tag that also carries its interrupt bit, with tag interrupts enabled, makes normal completion and the tag interrupt fall in the same WRAP cycle. The bench builds such a tag with one data quadword. It requires both `done_flag` and `tagirq_flag` to be set, the start bit to read 0 and exactly that one beat to be delivered.

// File: rtl/dmachain_pkg.sv
package dmachain_pkg;

    typedef enum logic [2:0] {
        OP_REFE = 3'd0,
        OP_CNT  = 3'd1,
        OP_NEXT = 3'd2,
        OP_REF  = 3'd3,
        OP_REFS = 3'd4,
        OP_CALL = 3'd5,
        OP_RET  = 3'd6,
        OP_END  = 3'd7
    } tag_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_MOVE,
        S_WRAP
    } seq_state_e;

    localparam logic [1:0]  MODE_CHAIN    = 2'd1;
    localparam logic [31:0] PHYS_MASK     = 32'h1FFF_FFF0;
    localparam logic [31:0] SPR_MASK      = 32'h0000_3FF0;
    localparam logic [31:0] SPR_WIN_LO    = 32'h1000_0000;
    localparam logic [31:0] SPR_WIN_HI    = 32'h1000_4000;
    localparam logic [31:0] QW_BYTES      = 32'd16;

endpackage

// File: rtl/dmachain_addr_map.sv
module dmachain_addr_map
    import dmachain_pkg::*;
#(
    parameter logic [31:0] MAIN_BYTES = 32'h0200_0000
) (
    input  logic [31:0] raw,
    output logic        hit,
    output logic        spr,
    output logic [31:0] off
);
    logic [31:0] phys;

    always_comb begin
        phys = raw & PHYS_MASK;
        hit  = 1'b1;
        spr  = 1'b0;
        off  = phys;
        if (raw[31]) begin
            spr = 1'b1;
            off = raw & SPR_MASK;
        end else if (phys < MAIN_BYTES) begin
            off = phys;
        end else if (phys >= SPR_WIN_LO && phys < SPR_WIN_HI) begin
            spr = 1'b1;
            off = phys & SPR_MASK;
        end else begin
            hit = 1'b0;
            off = '0;
        end
    end
endmodule

// File: rtl/dmachain_stack.sv
module dmachain_stack #(
    parameter int W     = 32,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0] ent [DEPTH];

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)      count <= '0;
        else if (push && !full) count <= count + 1'b1;
        else if (pop && !empty) count <= count - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             ent[g] <= '0;
            else if (push && count == CW'(g))       ent[g] <= din;
        end
    end

    always_comb begin
        top = '0;
        for (int k = 0; k < DEPTH; k++)
            if (count == CW'(k + 1)) top = ent[k];
    end
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
    import dmachain_pkg::*;
#(
    parameter logic [31:0] MAIN_BYTES  = 32'h0200_0000,
    parameter int          STACK_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [31:0]  cfg_ctrl,
    input  logic [31:0]  cfg_tadr,
    output logic [31:0]  ctrl_out,
    output logic         mem_req,
    output logic [31:0]  mem_addr,
    output logic         mem_spr,
    input  logic         mem_ack,
    input  logic [127:0] mem_rdata,
    output logic         dout_valid,
    output logic [127:0] dout_data,
    output logic         done_flag,
    output logic         tagirq_flag,
    output logic         buserr_flag,
    output logic         stackerr_flag
);
    localparam int SCW = $clog2(STACK_DEPTH + 1);

    seq_state_e state, nxt;

    logic [31:0] tadr, madr, tag_adr;
    logic [15:0] qwc, tagf;
    tag_op_e     op;
    logic        tag_irq, end_pend, irq_pend;
    logic        dir, tte, tie, str;
    logic [1:0]  mode;

    logic        map_hit, map_spr;
    logic [31:0] map_off, map_in;
    logic [31:0] follow, after, st_top;
    logic [SCW-1:0] st_cnt;
    logic        st_full, st_empty, st_push, st_pop, st_clr, stack_err;
    logic        cfg_unused;

    assign cfg_unused = ^{cfg_ctrl[15:9], cfg_ctrl[5:4], cfg_ctrl[1]};

    assign map_in = (state == S_FETCH) ? tadr : madr;

    dmachain_addr_map #(.MAIN_BYTES(MAIN_BYTES)) u_map (
        .raw(map_in), .hit(map_hit), .spr(map_spr), .off(map_off)
    );

    assign follow    = tadr + QW_BYTES;
    assign after     = follow + {12'd0, qwc, 4'd0};
    assign st_clr    = (state == S_IDLE) && cfg_we;
    assign st_push   = (state == S_DECODE) && (op == OP_CALL) && !st_full;
    assign st_pop    = (state == S_DECODE) && (op == OP_RET)  && !st_empty;
    assign stack_err = (state == S_DECODE) &&
                       (((op == OP_CALL) && st_full) || ((op == OP_RET) && st_empty));

    dmachain_stack #(.W(32), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(st_clr), .push(st_push), .pop(st_pop),
        .din(after), .top(st_top), .count(st_cnt), .full(st_full), .empty(st_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (cfg_we && cfg_ctrl[8] && cfg_ctrl[3:2] == MODE_CHAIN) nxt = S_FETCH;
            S_FETCH:  if (!map_hit) nxt = S_IDLE;
                      else if (mem_ack) nxt = S_DECODE;
            S_DECODE: if (stack_err) nxt = S_IDLE;
                      else if (qwc != '0) nxt = S_MOVE;
                      else nxt = S_WRAP;
            S_MOVE:   if (!map_hit) nxt = S_IDLE;
                      else if (mem_ack && qwc == 16'd1) nxt = S_WRAP;
            S_WRAP:   if (end_pend || irq_pend) nxt = S_IDLE;
                      else nxt = S_FETCH;
        endcase
    end

    // Datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tadr <= '0; madr <= '0; qwc <= '0; tagf <= '0; tag_adr <= '0;
            op <= OP_REFE; tag_irq <= 1'b0; end_pend <= 1'b0; irq_pend <= 1'b0;
            dir <= 1'b0; tte <= 1'b0; tie <= 1'b0; str <= 1'b0; mode <= '0;
            done_flag <= 1'b0; tagirq_flag <= 1'b0;
            buserr_flag <= 1'b0; stackerr_flag <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (cfg_we) begin
                    dir  <= cfg_ctrl[0];
                    mode <= cfg_ctrl[3:2];
                    tte  <= cfg_ctrl[6];
                    tie  <= cfg_ctrl[7];
                    str  <= cfg_ctrl[8] && (cfg_ctrl[3:2] == MODE_CHAIN);
                    tagf <= cfg_ctrl[31:16];
                    tadr <= cfg_tadr;
                    done_flag <= 1'b0; tagirq_flag <= 1'b0;
                    buserr_flag <= 1'b0; stackerr_flag <= 1'b0;
                end
                S_FETCH: if (!map_hit) begin
                    buserr_flag <= 1'b1;
                    str         <= 1'b0;
                end else if (mem_ack) begin
                    qwc     <= mem_rdata[15:0];
                    tagf    <= mem_rdata[31:16];
                    op      <= tag_op_e'(mem_rdata[30:28]);
                    tag_irq <= mem_rdata[31];
                    tag_adr <= mem_rdata[63:32];
                end
                S_DECODE: if (stack_err) begin
                    stackerr_flag <= 1'b1;
                    str           <= 1'b0;
                end else begin
                    end_pend <= (op == OP_REFE) || (op == OP_END);
                    irq_pend <= tie && tag_irq;
                    madr <= (op == OP_REFE || op == OP_REF || op == OP_REFS) ? tag_adr : follow;
                    unique case (op)
                        OP_CNT, OP_END:           tadr <= after;
                        OP_NEXT, OP_CALL:         tadr <= tag_adr;
                        OP_RET:                   tadr <= st_top;
                        OP_REFE, OP_REF, OP_REFS: tadr <= follow;
                    endcase
                end
                S_MOVE: if (!map_hit) begin
                    buserr_flag <= 1'b1;
                    str         <= 1'b0;
                end else if (mem_ack) begin
                    madr <= madr + QW_BYTES;
                    qwc  <= qwc - 16'd1;
                end
                S_WRAP: begin
                    if (end_pend) done_flag   <= 1'b1;
                    if (irq_pend) tagirq_flag <= 1'b1;
                    if (end_pend || irq_pend) str <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    assign mem_req    = ((state == S_FETCH) || (state == S_MOVE)) && map_hit;
    assign mem_addr   = mem_req ? map_off : '0;
    assign mem_spr    = mem_req && map_spr;
    assign dout_valid = (state == S_MOVE) && map_hit && mem_ack;
    assign dout_data  = mem_rdata;
    assign ctrl_out   = {tagf, 7'd0, str, tie, tte, 2'(st_cnt), mode, 1'b0, dir};

endmodule

// File: rtl/dmachain_checker.sv
module dmachain_checker #(
    parameter int STACK_DEPTH = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_out,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_spr,
    input logic        mem_ack,
    input logic        dout_valid,
    input logic        done_flag,
    input logic        tagirq_flag,
    input logic        buserr_flag,
    input logic        stackerr_flag
);
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_spr));

    a_r12_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[3:0] == 4'd0);

    a_r12_beat: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> mem_ack && mem_req);

    a_r9_spr_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_spr |-> mem_addr[31:14] == '0);

    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_out[8] |-> !mem_req);

    a_r5_done_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !ctrl_out[8]);

    a_r8_irq_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tagirq_flag) |-> !ctrl_out[8]);

    a_r10_berr_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buserr_flag) |-> !ctrl_out[8]);

    a_r7_stk_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stackerr_flag) |-> !ctrl_out[8]);

    a_r6_depth: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ctrl_out[5:4]) <= STACK_DEPTH);
endmodule

bind chain_dma_seq dmachain_checker #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_out(ctrl_out), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_spr(mem_spr), .mem_ack(mem_ack),
    .dout_valid(dout_valid), .done_flag(done_flag), .tagirq_flag(tagirq_flag),
    .buserr_flag(buserr_flag), .stackerr_flag(stackerr_flag)
);

// File: tb/chain_dma_seq_test.sv
module chain_dma_seq_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n, cfg_we, mem_req, mem_spr, mem_ack, dout_valid;
    logic [31:0]  cfg_ctrl, cfg_tadr, ctrl_out, mem_addr;
    logic [127:0] mem_rdata, dout_data;
    logic         done_flag, tagirq_flag, buserr_flag, stackerr_flag;

    chain_dma_seq uut (.*);

    int n_chk = 0, n_fail = 0;
    string cur_req = "R4";
    logic [127:0] expq[$];
    bit [63:0] tagmem [bit [32:0]];

    localparam logic [31:0] GO     = 32'h0000_0104;
    localparam logic [31:0] GO_TIE = 32'h0000_0184;

    function automatic logic [127:0] pat(input bit spr, input logic [31:0] off);
        return {off ^ 32'hA5A5_0000, off + 32'h11, {31'd0, spr}, off};
    endfunction

    function automatic logic [63:0] mk(input logic [2:0] id, input logic [15:0] q,
                                       input bit irq, input logic [31:0] adr);
        return {adr, irq, id, 2'b00, 10'd0, q};
    endfunction

    task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic put(input bit spr, input logic [31:0] off, input logic [63:0] t);
        tagmem[{spr, off}] = t;
    endtask

    task automatic expect_beat(input bit spr, input logic [31:0] off);
        expq.push_back(pat(spr, off));
    endtask

    // memory responder, one cycle latency
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (tagmem.exists({mem_spr, mem_addr}))
                mem_rdata <= {64'd0, tagmem[{mem_spr, mem_addr}]};
            else
                mem_rdata <= pat(mem_spr, mem_addr);
        end else mem_ack <= 1'b0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (expq.size() == 0) chk({cur_req, " unexpected beat"}, dout_data, 128'hX);
            else chk({cur_req, " data beat"}, dout_data, expq.pop_front());
        end
    end

    task automatic run(input logic [31:0] ctrl, input logic [31:0] tadr, input bit poke);
        int k;
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = ctrl; cfg_tadr = tadr;
        @(negedge clk);
        cfg_we = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_we = 1'b1; cfg_ctrl = GO; cfg_tadr = 32'h0F00_0000;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        k = 0;
        while (ctrl_out[8] && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 3000) chk({cur_req, " chain timeout"}, 1, 0);
        @(negedge clk);
        chk({cur_req, " beats left"}, 128'(expq.size()), 0);
    endtask

    task automatic flags(input string r, input logic [3:0] exp);
        chk(r, {done_flag, tagirq_flag, buserr_flag, stackerr_flag}, exp);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ctrl = '0; cfg_tadr = '0; mem_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ctrl_out", ctrl_out, 0);
        flags("R1 flags", 4'b0000);
        chk("R1 mem_req", mem_req, 0);

        // R2: wrong mode does not start
        cur_req = "R2";
        put(0, 32'h0000_0500, mk(3'd7, 16'd1, 0, 0));
        run(32'h0000_0100, 32'h0000_0500, 0);
        chk("R2 mode!=chain start bit", ctrl_out[8], 0);
        chk("R2 mode!=chain mode field", ctrl_out[3:2], 0);
        flags("R2 no flags", 4'b0000);

        // R4 R5 R6 R11: full chain
        cur_req = "R6";
        put(0, 32'h1000, mk(3'd1, 16'd2, 0, 0));
        put(0, 32'h1030, mk(3'd2, 16'd1, 0, 32'h2000));
        put(0, 32'h2000, mk(3'd3, 16'd2, 0, 32'h3000));
        put(0, 32'h2010, mk(3'd5, 16'd1, 0, 32'h4000));
        put(0, 32'h4000, mk(3'd5, 16'd0, 0, 32'h5000));
        put(0, 32'h5000, mk(3'd6, 16'd1, 0, 0));
        put(0, 32'h4010, mk(3'd6, 16'd0, 0, 0));
        put(0, 32'h2030, mk(3'd7, 16'd1, 0, 0));
        expect_beat(0, 32'h1010); expect_beat(0, 32'h1020);
        expect_beat(0, 32'h1040);
        expect_beat(0, 32'h3000); expect_beat(0, 32'h3010);
        expect_beat(0, 32'h2020);
        expect_beat(0, 32'h5010);
        expect_beat(0, 32'h2040);
        run(GO, 32'h1000, 0);
        flags("R5 end tag done", 4'b1000);
        chk("R5 start cleared", ctrl_out[8], 0);
        chk("R6 stack depth after returns", ctrl_out[5:4], 0);
        chk("R3 tag field of end tag", ctrl_out[31:16], mk(3'd7, 16'd1, 0, 0) >> 16);
        chk("R11 zero-count tags moved nothing", 128'(expq.size()), 0);

        // R9: scratchpad via window and via select bit, R5 REFE
        cur_req = "R9";
        put(1, 32'h0100, mk(3'd0, 16'd2, 0, 32'h8000_0020));
        expect_beat(1, 32'h0020); expect_beat(1, 32'h0030);
        run(GO, 32'h1000_0100, 0);
        flags("R5 REFE done", 4'b1000);
        chk("R9 REFE tag seen", ctrl_out[31:16], mk(3'd0, 16'd2, 0, 0) >> 16);

        // R9: high bits masked off
        cur_req = "R9";
        put(0, 32'h6000, mk(3'd7, 16'd0, 0, 0));
        run(GO, 32'h6000_6008, 0);
        flags("R9 masked address reached tag", 4'b1000);
        chk("R9 masked tag field", ctrl_out[31:16], mk(3'd7, 16'd0, 0, 0) >> 16);

        // R8: tag interrupt with enable
        cur_req = "R8";
        put(0, 32'h8000, mk(3'd1, 16'd1, 1, 0));
        put(0, 32'h8020, mk(3'd7, 16'd1, 0, 0));
        expect_beat(0, 32'h8010);
        run(GO_TIE, 32'h8000, 0);
        flags("R8 stop on tag irq", 4'b0100);
        chk("R8 enable readback", ctrl_out[8:7], 2'b01);

        // R8 disabled + R2 write while running ignored
        cur_req = "R8";
        expect_beat(0, 32'h8010); expect_beat(0, 32'h8030);
        run(GO, 32'h8000, 1);
        flags("R8/R2 irq ignored, running write ignored", 4'b1000);

        // same-cycle done and tag irq
        cur_req = "R8";
        put(0, 32'h9000, mk(3'd7, 16'd1, 1, 0));
        expect_beat(0, 32'h9010);
        run(GO_TIE, 32'h9000, 0);
        flags("R8/R5 done and tag irq together", 4'b1100);
        chk("R5 start cleared on joint stop", ctrl_out[8], 0);

        // R10: bus error on tag and on data
        cur_req = "R10";
        run(GO, 32'h0F00_0000, 0);
        flags("R10 tag address unmapped", 4'b0010);
        chk("R10 start cleared", ctrl_out[8], 0);
        put(0, 32'hA000, mk(3'd3, 16'd1, 0, 32'h0800_0000));
        run(GO, 32'hA000, 0);
        flags("R10 data address unmapped", 4'b0010);
        chk("R3 tag field before error", ctrl_out[31:16], mk(3'd3, 16'd1, 0, 0) >> 16);

        // R7: overflow and underflow
        cur_req = "R7";
        put(0, 32'h7000, mk(3'd5, 16'd0, 0, 32'h7100));
        put(0, 32'h7100, mk(3'd5, 16'd0, 0, 32'h7200));
        put(0, 32'h7200, mk(3'd5, 16'd1, 0, 32'h7300));
        run(GO, 32'h7000, 0);
        flags("R7 call on full stack", 4'b0001);
        chk("R6 depth reads 2", ctrl_out[5:4], 2);
        put(0, 32'h7400, mk(3'd6, 16'd1, 0, 0));
        run(GO, 32'h7400, 0);
        flags("R7 return on empty stack", 4'b0001);
        chk("R7 start cleared", ctrl_out[8], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule